// File: doc/BRIEF.md
# Daisy-Chain Bus Grant Arbiter

This block decides which of several bus masters owns a shared bus. Every master raises its own request bit, and all bits are OR-ed onto one shared request line, so the controller only learns that somebody wants the bus, not who. When the shared line is high and the bus is free, the controller drives a single grant into the head of a chain of identical cells, one per master. The grant ripples from cell to cell. The first cell whose master is requesting keeps it and does not pass it further along.

The winning master's grant bit and the bus-busy flag both come from registers and rise on the clock edge after the request is seen. The owner keeps the bus for as long as it holds its request, even if a master nearer the head of the chain asks meanwhile. When the owner drops its request, its grant and the busy flag clear on the next edge. The chain then arbitrates again among the masters that are still asking, and the new owner's grant appears one edge later.

Top module: `daisy_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, `gnt` becomes all zeros and `busy` becomes 0 after that edge.
- R2: If no master owns the bus and `req` is nonzero before a clock edge, then after that edge `gnt` has exactly the bit of the lowest-index requesting master set. Index 0 is the cell nearest the controller and has the highest priority.
- R3: While the owner keeps its `req` bit high, `gnt` does not change at the next edge, whatever the other request bits do. A higher-priority request does not preempt the owner.
- R4: If the owner's `req` bit is low before a clock edge, then `gnt` is all zeros after that edge, even when other masters are requesting.
- R5: At most one bit of `gnt` is high in any cycle.
- R6: `busy` is high exactly in the cycles in which some bit of `gnt` is high.
- R7: With no owner and `req` all zeros before an edge, `gnt` stays all zeros and `busy` stays 0 after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MASTERS | Per-master bus request, OR-ed onto the shared line |
| gnt | output | N_MASTERS | Registered one-hot bus grant, bit 0 is highest priority |
| busy | output | 1 | Registered bus-busy flag |

## Verification
The bench builds the arbiter with its default of four masters. With four masters, all 16 request patterns and every ordered pair of them are within reach. Each pair is driven as a held pattern, then a switch to the second pattern, then an idle cycle. This sweep covers every owner position facing every set of higher- and lower-priority contenders, both at grant time and at release time. After each edge a small arithmetic model, holding only the owner's index, supplies the expected grant vector and busy flag.

// File: rtl/daisy_pkg.sv
package daisy_pkg;
  localparam int DEFAULT_MASTERS = 4;

  typedef enum logic {
    ARB_FREE = 1'b0,
    ARB_HELD = 1'b1
  } arb_state_t;
endpackage

// File: rtl/req_wire_or.sv
module req_wire_or #(
  parameter int N_MASTERS = 4
) (
  input  logic [N_MASTERS-1:0] req,
  output logic                 shared_req
);
  // Logical model of the open-collector shared request line
  assign shared_req = |req;
endmodule

// File: rtl/chain_cell.sv
module chain_cell (
  input  logic clk,
  input  logic rst,
  input  logic grant_in,
  input  logic req,
  output logic grant_out,
  output logic own,
  output logic own_nxt
);
  // A requesting cell absorbs the grant; otherwise it passes it on
  assign grant_out = grant_in & ~req;
  assign own_nxt   = own ? req : (grant_in & req);

  always_ff @(posedge clk) begin
    if (rst) own <= 1'b0;
    else     own <= own_nxt;
  end
endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
  import daisy_pkg::*;
#(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shared_req,
  input  logic [N_MASTERS-1:0] own_nxt,
  output logic                 chain_head,
  output logic                 busy
);
  arb_state_t state_q, state_d;

  assign chain_head = shared_req & (state_q == ARB_FREE);
  assign state_d    = (|own_nxt) ? ARB_HELD : ARB_FREE;
  assign busy       = (state_q == ARB_HELD);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ARB_FREE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/daisy_arbiter.sv
module daisy_arbiter
  import daisy_pkg::*;
#(
  parameter int N_MASTERS = DEFAULT_MASTERS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req,
  output logic [N_MASTERS-1:0] gnt,
  output logic                 busy
);
  logic                 shared_req;
  logic                 chain_head;
  logic [N_MASTERS:0]   ripple;
  logic [N_MASTERS-1:0] own_nxt;

  req_wire_or #(.N_MASTERS(N_MASTERS)) u_or (
    .req        (req),
    .shared_req (shared_req)
  );

  chain_ctrl #(.N_MASTERS(N_MASTERS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .shared_req (shared_req),
    .own_nxt    (own_nxt),
    .chain_head (chain_head),
    .busy       (busy)
  );

  assign ripple[0] = chain_head;

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_cell
    chain_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .grant_in  (ripple[i]),
      .req       (req[i]),
      .grant_out (ripple[i+1]),
      .own       (gnt[i]),
      .own_nxt   (own_nxt[i])
    );
  end
endmodule

// File: rtl/daisy_arbiter_checker.sv
module daisy_arbiter_checker #(
  parameter int N_MASTERS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_MASTERS-1:0] req,
  input logic [N_MASTERS-1:0] gnt,
  input logic                 busy
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (gnt == '0 && !busy));

  a_r2_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && req != '0) |=> (gnt == $past(req & (~req + 1'b1))));

  a_r3_no_preempt: assert property (@(posedge clk) disable iff (rst)
    ((gnt & req) != '0) |=> (gnt == $past(gnt)));

  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0 && (gnt & req) == '0) |=> (gnt == '0));

  a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  a_r6_busy_match: assert property (@(posedge clk) disable iff (rst)
    busy == (gnt != '0));

  a_r7_idle: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && req == '0) |=> (gnt == '0 && !busy));
endmodule

bind daisy_arbiter daisy_arbiter_checker #(.N_MASTERS(N_MASTERS)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .req  (req),
  .gnt  (gnt),
  .busy (busy)
);

// File: tb/sim_daisy_arbiter.sv
module sim_daisy_arbiter;
  localparam int N = 4;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [N-1:0] gnt;
  logic         busy;

  int checks = 0;
  int fails  = 0;
  int owner  = -1;
  bit done   = 1'b0;

  daisy_arbiter #(.N_MASTERS(N)) u0 (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .gnt  (gnt),
    .busy (busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (req %b)", tag, act, exp, req);
    end
  endtask

  function automatic logic [N-1:0] owner_vec(input int o);
    logic [N-1:0] v = '0;
    if (o >= 0) v[o] = 1'b1;
    return v;
  endfunction

  task automatic step(input logic [N-1:0] r);
    int    prev;
    string tag;
    @(negedge clk);
    req = r;
    @(posedge clk);
    prev = owner;
    if (owner >= 0) begin
      if (!r[owner]) owner = -1;
    end else begin
      for (int i = N - 1; i >= 0; i--) if (r[i]) owner = i;
    end
    if (prev < 0 && owner >= 0)       tag = "R2";
    else if (prev >= 0 && owner >= 0) tag = "R3";
    else if (prev >= 0)               tag = "R4";
    else                              tag = "R7";
    #1;
    check(tag, gnt, owner_vec(owner));
    check("R5", {{(N-1){1'b0}}, 1'($countones(gnt) <= 1)}, {{(N-1){1'b0}}, 1'b1});
    check("R6", {{(N-1){1'b0}}, busy}, {{(N-1){1'b0}}, 1'(owner >= 0)});
  endtask

  initial begin
    req = '1;
    repeat (2) @(posedge clk);
    #1;
    check("R1", gnt, '0);
    check("R1", {{(N-1){1'b0}}, busy}, '0);
    @(negedge clk);
    rst = 1'b0;
    req = '0;
    owner = -1;
    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        step(N'(a));
        step(N'(a));
        step(N'(b));
        step(N'(b));
        step('0);
      end
    end
    // higher-priority contender arrives while master 3 owns the bus
    step(4'b1000);
    step(4'b1001);
    step(4'b0111);
    step(4'b0110);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule